// File: doc/BRIEF.md
# Search Co-Processor Bring-Up Sequencer

This block sits on the host side of an external content-addressable search co-processor, or of a cascade of up to eight such devices. It takes them from reset to normal operation. A single start pulse runs the whole sequence:

1. The block holds the devices' reset low with the request strobe low.
2. It releases reset.
3. It drives the daisy-chain configuration line high long enough for every device in the cascade to take its identity.
4. It issues a fixed run of two-phase write transactions over a 7-bit command bus and a 72-bit request bus.

The writes go in this order:

1. An optional early write that enables the handshake outputs of the last device.
2. Zero-fill writes to every data-array entry of every device.
3. Writes to the mask and reply-width registers listed in a parameter table.
4. A final configuration word for each device.

When the last write completes, a done flag rises. It stays high until the next start.

Each write takes exactly four cycles: two address cycles with the strobe high, then two data cycles with the strobe low. Writes follow each other with no idle cycle. The table's per-entry enable bits choose which register writes are made, and disabled entries cost no time. The array depth, the reset and chain lengths, and the register table are parameters. The default depth of 65,536 entries costs 262,144 cycles per device.

Top module: `cam_init_seq`

## Requirements
- R1: After start is sampled, `dev_rst_n_o` is low for exactly RST_CYC (32) cycles with `req_stb_o` low, then goes high.
- R2: Immediately after reset release, `chain_o` is high for exactly CHAIN_CYC (16) cycles times the device count N, with no strobe. N is `dev_cnt_i` sampled at start; 0 counts as 1 and values above MAX_DEV count as MAX_DEV.
- R3: Every write has the same four cycles:
  - the strobe is high for 2 cycles and then low for 2 cycles;
  - `cmd_o` is 7'b0000100 (bits [3:0]=0100) while the strobe is high and zero while it is low;
  - `req_o` holds its value through both cycles of each phase.
- R4: In the address phase of a register write, bits [8:1] carry the register address and bits [33:26] carry the target device number. All other bits are zero.
- R5: When `hs_en_i` is high at start, the first write targets address 0x03 of device N-1, and its data word has only bit 28 set.
- R6: Devices 0 to N-1 are cleared in order. Each device gets ENTRIES writes with entry indices ascending from 0. The address phase carries bits [25:24]=01, [23:22]=11, the entry index from bit 1 upward and the device number at [33:26]. The data phase is all zeros.
- R7: Next, for each device in ascending order, every table entry whose enable bit is set is written in ascending index order, with REG_ADDR[i] as address and REG_DATA[i] as data. Disabled entries produce no write and no idle cycle.
- R8: Last, each device in ascending order receives a write to address 0x03:
  - data bits 31 and 30 are set on every device;
  - bits 29 and 28 are set only on device N-1;
  - every other bit is zero.
- R9: Writes run back to back from the cycle after the chain phase ends. `done_o` rises in the cycle after the final data phase. While `done_o` is high, it stays high with the strobe and chain low and reset released, until a new start.
- R10: A start pulse during a running sequence is ignored; the sequence completes unchanged.
- R11: While the system reset is asserted, `dev_rst_n_o`, `req_stb_o`, `chain_o` and `done_o` are low and both buses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| start_i | input | 1 | Starts a sequence when idle or done |
| dev_cnt_i | input | 4 | Number of cascaded devices, sampled at start |
| hs_en_i | input | 1 | Selects the early handshake-enable write, sampled at start |
| dev_rst_n_o | output | 1 | Active-low reset to the devices |
| chain_o | output | 1 | Daisy-chain configuration line |
| req_stb_o | output | 1 | Request strobe, high during address phases |
| cmd_o | output | 7 | Command bus |
| req_o | output | 72 | Request bus |
| done_o | output | 1 | Sequence complete |

## Verification
Every output is decoded from state registers, so it follows the clock edge that sampled start or advanced the sequence by one cycle. Reset drops in the cycle after start is sampled, and the chain line rises in the cycle after the 32nd reset cycle. The first address phase starts in the cycle after the last chain cycle, each write takes four cycles, and done follows the last data cycle by one cycle.

The bench drives inputs and samples outputs on falling edges and walks the run cycle by cycle. It measures the reset and chain lengths as run lengths. It decodes each four-cycle window as one write, so any gap or extra cycle shows up as a format mismatch. Each decoded write is compared with a list the bench builds from N, the handshake option and the table parameters.

// File: rtl/cam_init_seq.sv
module cam_init_seq #(
  parameter int ENTRIES   = 65536,
  parameter int RST_CYC   = 32,
  parameter int CHAIN_CYC = 16,
  parameter int MAX_DEV   = 8,
  parameter int NREG      = 4,
  parameter logic [NREG*8-1:0]  REG_ADDR = {8'h07, 8'h06, 8'h05, 8'h04},
  parameter logic [NREG*72-1:0] REG_DATA = '0,
  parameter logic [NREG-1:0]    REG_EN   = '1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [3:0]  dev_cnt_i,
  input  logic        hs_en_i,
  output logic        dev_rst_n_o,
  output logic        chain_o,
  output logic        req_stb_o,
  output logic [6:0]  cmd_o,
  output logic [71:0] req_o,
  output logic        done_o
);
  localparam int ENT_W     = $clog2(ENTRIES);
  localparam int CHAIN_MAX = CHAIN_CYC * MAX_DEV;
  localparam int CNT_MAX   = (RST_CYC > CHAIN_MAX) ? RST_CYC : CHAIN_MAX;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);
  localparam int IDX_W     = $clog2(NREG + 1);
  localparam logic [IDX_W-1:0] NONE = IDX_W'(NREG);
  localparam logic [7:0] CFG_ADDR = 8'h03;
  localparam logic [6:0] CMD_WR   = 7'b0000100;

  typedef enum logic [2:0] {S_IDLE, S_RST, S_CHAIN, S_HS, S_CLR, S_REG, S_CFG, S_DONE} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       ph;
  logic [ENT_W-1:0] ent;
  logic [3:0]       dev, ndev;
  logic             hs;
  logic [IDX_W-1:0] ridx;

  function automatic logic [IDX_W-1:0] next_en(input logic [IDX_W-1:0] from);
    next_en = NONE;
    for (int i = NREG - 1; i >= 0; i--)
      if (REG_EN[i] && IDX_W'(i) >= from) next_en = IDX_W'(i);
  endfunction

  logic [IDX_W-1:0] first_en, nxt_en;
  logic [3:0]       n_in;
  logic [CNT_W-1:0] chain_len;
  logic             last, wr, aph, wr_end;

  assign first_en  = next_en('0);
  assign nxt_en    = next_en(ridx + IDX_W'(1));
  assign n_in      = (dev_cnt_i == 4'd0) ? 4'd1 :
                     (int'(dev_cnt_i) > MAX_DEV) ? 4'(MAX_DEV) : dev_cnt_i;
  assign chain_len = CNT_W'(CHAIN_CYC * int'(ndev));
  assign last      = (dev == ndev - 4'd1);
  assign wr        = (st == S_HS) || (st == S_CLR) || (st == S_REG) || (st == S_CFG);
  assign aph       = wr && !ph[1];
  assign wr_end    = (ph == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; ph <= '0; ent <= '0;
      dev <= '0; ndev <= 4'd1; hs <= 1'b0; ridx <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE:
          if (start_i) begin
            st <= S_RST; cnt <= '0; ndev <= n_in; hs <= hs_en_i;
          end
        S_RST:
          if (cnt == CNT_W'(RST_CYC - 1)) begin st <= S_CHAIN; cnt <= '0; end
          else cnt <= cnt + CNT_W'(1);
        S_CHAIN:
          if (cnt == chain_len - CNT_W'(1)) begin
            cnt <= '0; ph <= '0; ent <= '0;
            if (hs) begin st <= S_HS; dev <= ndev - 4'd1; end
            else begin st <= S_CLR; dev <= '0; end
          end else cnt <= cnt + CNT_W'(1);
        default: begin
          ph <= ph + 2'd1;
          if (wr_end) begin
            if (st == S_HS) begin
              st <= S_CLR; dev <= '0; ent <= '0;
            end else if (st == S_CLR) begin
              if (ent == ENT_W'(ENTRIES - 1)) begin
                ent <= '0;
                if (last) begin
                  dev <= '0; ridx <= first_en;
                  st <= (first_en == NONE) ? S_CFG : S_REG;
                end else dev <= dev + 4'd1;
              end else ent <= ent + ENT_W'(1);
            end else if (st == S_REG) begin
              if (nxt_en == NONE) begin
                ridx <= first_en;
                if (last) begin dev <= '0; st <= S_CFG; end
                else dev <= dev + 4'd1;
              end else ridx <= nxt_en;
            end else begin
              if (last) st <= S_DONE;
              else dev <= dev + 4'd1;
            end
          end
        end
      endcase
    end
  end

  assign dev_rst_n_o = !(st == S_IDLE || st == S_RST);
  assign chain_o     = (st == S_CHAIN);
  assign done_o      = (st == S_DONE);
  assign req_stb_o   = aph;
  assign cmd_o       = aph ? CMD_WR : '0;

  always_comb begin
    req_o = '0;
    if (aph) begin
      req_o[33:26] = 8'(dev);
      if (st == S_CLR) begin
        req_o[25:24]   = 2'b01;
        req_o[23:22]   = 2'b11;
        req_o[ENT_W:1] = ent;
      end else if (st == S_REG) begin
        req_o[8:1] = REG_ADDR[int'(ridx)*8 +: 8];
      end else begin
        req_o[8:1] = CFG_ADDR;
      end
    end else if (wr) begin
      case (st)
        S_HS:  req_o[28] = 1'b1;
        S_REG: req_o = REG_DATA[int'(ridx)*72 +: 72];
        S_CFG: begin
          req_o[31:30] = 2'b11;
          req_o[29]    = last;
          req_o[28]    = last;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cam_init_seq_chk.sv
module cam_init_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        dev_rst_n_o,
  input logic        chain_o,
  input logic        req_stb_o,
  input logic [6:0]  cmd_o,
  input logic [71:0] req_o,
  input logic        done_o
);
  p_no_stb_in_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_rst_n_o |-> !req_stb_o);
  p_chain_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    chain_o |-> (dev_rst_n_o && !req_stb_o));
  p_cmd_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_stb_o |-> (cmd_o == 7'b0000100));
  p_cmd_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_stb_o |-> (cmd_o == 7'd0));
  p_addr_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_stb_o) |=> (req_stb_o && $stable(req_o)));
  p_data_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_stb_o) |=> (!req_stb_o && $stable(req_o)));
  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (dev_rst_n_o && !chain_o && !req_stb_o));
  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);
  p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_o && start_i) |=> (dev_rst_n_o && !done_o));
endmodule

bind cam_init_seq cam_init_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .dev_rst_n_o(dev_rst_n_o),
  .chain_o(chain_o), .req_stb_o(req_stb_o), .cmd_o(cmd_o), .req_o(req_o),
  .done_o(done_o)
);

// File: tb/cam_init_seq_tb_top.sv
module cam_init_seq_tb_top;
  localparam int ENT = 8;
  localparam logic [31:0]  TB_ADDR = {8'h30, 8'h05, 8'h20, 8'h04};
  localparam logic [287:0] TB_DATA = {72'hC3_0123_4567_89AB_CDEF, 72'hB2_FFFF_0000_FFFF_0000,
                                      72'hA1_5555_AAAA_5555_AAAA, 72'h90_0000_0000_0000_0007};
  localparam logic [3:0]   TB_EN   = 4'b1101;

  logic clk = 0, rst_n = 0, start = 0, hs_en = 0;
  logic [3:0] dev_cnt = 0;
  logic dev_rst_n, chain, stb, done;
  logic [6:0] cmd;
  logic [71:0] req;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  cam_init_seq #(.ENTRIES(ENT), .REG_ADDR(TB_ADDR), .REG_DATA(TB_DATA), .REG_EN(TB_EN)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .dev_cnt_i(dev_cnt), .hs_en_i(hs_en),
    .dev_rst_n_o(dev_rst_n), .chain_o(chain), .req_stb_o(stb), .cmd_o(cmd),
    .req_o(req), .done_o(done));

  logic [71:0] ea [0:255];
  logic [71:0] ed [0:255];
  string       et [0:255];
  int ne;

  task automatic chk(input bit ok, input string r, input logic [71:0] act, input logic [71:0] exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s act=%h exp=%h", r, act, exp); end
  endtask

  function automatic logic [71:0] a_word(int d, logic [7:0] a);
    logic [71:0] w = '0;
    w[33:26] = 8'(d); w[8:1] = a;
    return w;
  endfunction

  task automatic build(int n, bit hs);
    ne = 0;
    if (hs) begin ea[ne] = a_word(n-1, 8'h03); ed[ne] = 72'd1 << 28; et[ne] = "R5"; ne++; end
    for (int d = 0; d < n; d++)
      for (int e = 0; e < ENT; e++) begin
        ea[ne] = '0; ea[ne][33:26] = 8'(d); ea[ne][25:22] = 4'b0111; ea[ne][15:1] = 15'(e);
        ed[ne] = '0; et[ne] = "R6"; ne++;
      end
    for (int d = 0; d < n; d++)
      for (int i = 0; i < 4; i++)
        if (TB_EN[i]) begin
          ea[ne] = a_word(d, TB_ADDR[i*8 +: 8]); ed[ne] = TB_DATA[i*72 +: 72]; et[ne] = "R4/R7"; ne++;
        end
    for (int d = 0; d < n; d++) begin
      ea[ne] = a_word(d, 8'h03);
      ed[ne] = (72'd3 << 30) | ((d == n-1) ? (72'd3 << 28) : 72'd0);
      et[ne] = "R4/R8"; ne++;
    end
  endtask

  task automatic run_seq(int n_req, bit hs, bit poke);
    int neff, c, k;
    logic [71:0] a0, d0;
    neff = (n_req == 0) ? 1 : n_req;
    build(neff, hs);
    @(negedge clk); start = 1; dev_cnt = 4'(n_req); hs_en = hs;
    @(negedge clk); start = 0;
    c = 0;
    while (!dev_rst_n && c < 1000) begin
      if (stb) chk(0, "R1 strobe in reset", 1, 0);
      c++; @(negedge clk);
    end
    chk(c == 32, "R1 reset length", 72'(c), 72'd32);
    c = 0;
    while (chain && c < 1000) begin
      if (stb) chk(0, "R2 strobe in chain", 1, 0);
      c++; @(negedge clk);
    end
    chk(c == 16*neff, "R2 chain length", 72'(c), 72'(16*neff));
    k = 0;
    while (!done && k < 250) begin
      chk(stb && cmd == 7'b0000100, "R3 addr cycle 1", {64'd0, stb, cmd}, {64'd0, 1'b1, 7'b0000100});
      a0 = req;
      if (poke && k == 2) start = 1;
      @(negedge clk); start = 0;
      chk(stb && cmd == 7'b0000100 && req == a0, "R3 addr cycle 2", req, a0);
      @(negedge clk);
      chk(!stb && cmd == 0, "R3 data cycle 1", {64'd0, stb, cmd}, 72'd0);
      d0 = req;
      @(negedge clk);
      chk(!stb && cmd == 0 && req == d0, "R3 data cycle 2", req, d0);
      if (k < ne) begin
        chk(a0 == ea[k], {et[k], " address phase"}, a0, ea[k]);
        chk(d0 == ed[k], {et[k], " data phase"}, d0, ed[k]);
      end
      k++;
      @(negedge clk);
    end
    chk(k == ne, poke ? "R10 R9 write count" : "R9 write count", 72'(k), 72'(ne));
    for (int i = 0; i < 4; i++) begin
      chk(done && !stb && !chain && dev_rst_n, "R9 done hold", {68'd0, done, stb, chain, dev_rst_n}, 72'b1001);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (600000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    chk(!dev_rst_n && !stb && !chain && !done && cmd == 0 && req == 0, "R11 reset state",
        {req[63:0], dev_rst_n, stb, chain, done, 4'd0}, 72'd0);
    rst_n = 1;
    @(negedge clk);
    run_seq(1, 1, 0);
    run_seq(8, 0, 1);
    run_seq(0, 1, 0);
    for (int r = 0; r < 5; r++)
      run_seq(1 + int'($urandom % 8), bit'($urandom % 2), bit'($urandom % 2));
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule